// File: doc/BRIEF.md
# Four-Bit ALU with Jump-Flag Generation

This block is the purely combinational arithmetic and logic stage of a small nibble-wide processor. It takes the two working operands, the present carry and jump flags, and a three-bit operation code. It returns a result, the register that result belongs in, and a new value with a write strobe for each flag. Storage, sequencing and memory all sit outside the block.

Each operation has its own side effect on the flags:

- **Add with carry** reports the carry out of the top bit. It sets the jump flag from the sign bit of the sum.
- **The two inversions** set the jump flag when the inverted value is zero.
- **The right rotate** passes through the carry flag. The old carry enters at the top bit, and the low bit that leaves becomes the new carry.
- **NAND and XOR** leave both flags alone.

When a flag is not written, its output copies the incoming flag. A register loaded from that output therefore keeps its value whether or not the strobe is honoured.

Top module: `nib_alu`

## Requirements
- R1: With op 0 (add), res_o equals (a_i + b_i + cf_i) modulo 16, cf_o equals the carry out of bit 3, cf_we_o is 1 and dst_b_o is 0.
- R2: With op 0, jf_we_o is 1 and jf_o equals bit 3 of res_o (two's-complement sign).
- R3: With op 1 (NAND), res_o equals ~(a_i & b_i), dst_b_o is 0 and both write enables are 0.
- R4: With op 2 (XOR), res_o equals a_i ^ b_i, dst_b_o is 0 and both write enables are 0.
- R5: With op 3 (rotate through carry), res_o equals {cf_i, a_i[3:1]}, cf_o equals a_i[0], cf_we_o is 1, jf_we_o is 0 and dst_b_o is 0.
- R6: With op 4 (invert A), res_o equals ~a_i, dst_b_o is 0, jf_we_o is 1, jf_o is 1 exactly when res_o is 0, and cf_we_o is 0.
- R7: With op 5 (invert B), res_o equals ~b_i, dst_b_o is 1 (destination B), jf_we_o is 1, jf_o is 1 exactly when res_o is 0, and cf_we_o is 0.
- R8: With op 6 or 7, res_o is 0, dst_b_o is 0 and both write enables are 0.
- R9: Whenever cf_we_o is 0, cf_o equals cf_i. Whenever jf_we_o is 0, jf_o equals jf_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code: 0 add, 1 NAND, 2 XOR, 3 rotate, 4 invert A, 5 invert B |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B |
| cf_i | input | 1 | Present carry flag |
| jf_i | input | 1 | Present jump flag |
| res_o | output | DATA_W | Operation result |
| dst_b_o | output | 1 | 1 when the result belongs in B, 0 for A |
| cf_o | output | 1 | Next carry flag |
| cf_we_o | output | 1 | Carry flag write enable |
| jf_o | output | 1 | Next jump flag |
| jf_we_o | output | 1 | Jump flag write enable |

## Verification
The embedded assertions check on every evaluation four things:

- Only add and rotate strobe the carry flag.
- A flag whose strobe is low echoes its input.
- Only invert-B selects destination B.
- Unused codes give a zero result with no strobes.

The arithmetic values cannot be shown that way: the sum and carry, the sign-derived jump flag, the bit that enters and leaves in the rotate, and the zero detection after inversion. The bench's exhaustive sweep against its own model exposes those, as do its directed vectors at the wrap-around and sign-change points.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_XOR  = 3'd2,
        OP_ROT  = 3'd3,
        OP_INVA = 3'd4,
        OP_INVB = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic dst_b;
        logic cf;
        logic cf_we;
        logic jf;
        logic jf_we;
    } alu_side_t;

endpackage

// File: rtl/nib_alu_adder.sv
module nib_alu_adder #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              co_o,
    output logic              neg_o
);
    localparam int SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] wide_d;

    always_comb begin
        wide_d = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_i};
        sum_o  = wide_d[DATA_W-1:0];
        co_o   = wide_d[SUM_W-1];
        neg_o  = wide_d[DATA_W-1];
    end
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic #(
    parameter int DATA_W = 4
) (
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              zero_o
);
    // sel: 0 NAND, 1 XOR, 2 invert A, 3 invert B
    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = ~(a_i & b_i);
            2'd1:    res_o = a_i ^ b_i;
            2'd2:    res_o = ~a_i;
            default: res_o = ~b_i;
        endcase
        zero_o = (res_o == '0);
    end
endmodule

// File: rtl/nib_alu_rotor.sv
module nib_alu_rotor #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              co_o
);
    always_comb begin
        res_o = {c_i, a_i[DATA_W-1:1]};
        co_o  = a_i[0];
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cf_i,
    input  logic              jf_i,
    output logic [DATA_W-1:0] res_o,
    output logic              dst_b_o,
    output logic              cf_o,
    output logic              cf_we_o,
    output logic              jf_o,
    output logic              jf_we_o
);
    logic [DATA_W-1:0] add_sum, log_res, rot_res;
    logic              add_co, add_neg, log_zero, rot_co;
    logic [1:0]        log_sel;
    alu_op_e           op;
    alu_side_t         side_d;
    logic [DATA_W-1:0] res_d;

    assign op = alu_op_e'(op_i);

    always_comb begin
        case (op)
            OP_NAND: log_sel = 2'd0;
            OP_XOR:  log_sel = 2'd1;
            OP_INVA: log_sel = 2'd2;
            default: log_sel = 2'd3;
        endcase
    end

    nib_alu_adder #(.DATA_W(DATA_W)) u_adder (
        .a_i(a_i), .b_i(b_i), .c_i(cf_i),
        .sum_o(add_sum), .co_o(add_co), .neg_o(add_neg)
    );

    nib_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .sel_i(log_sel), .a_i(a_i), .b_i(b_i),
        .res_o(log_res), .zero_o(log_zero)
    );

    nib_alu_rotor #(.DATA_W(DATA_W)) u_rotor (
        .a_i(a_i), .c_i(cf_i),
        .res_o(rot_res), .co_o(rot_co)
    );

    always_comb begin
        res_d  = '0;
        side_d = '{dst_b: 1'b0, cf: cf_i, cf_we: 1'b0, jf: jf_i, jf_we: 1'b0};
        case (op)
            OP_ADD: begin
                res_d        = add_sum;
                side_d.cf    = add_co;
                side_d.cf_we = 1'b1;
                side_d.jf    = add_neg;
                side_d.jf_we = 1'b1;
            end
            OP_NAND, OP_XOR: res_d = log_res;
            OP_ROT: begin
                res_d        = rot_res;
                side_d.cf    = rot_co;
                side_d.cf_we = 1'b1;
            end
            OP_INVA, OP_INVB: begin
                res_d        = log_res;
                side_d.dst_b = (op == OP_INVB);
                side_d.jf    = log_zero;
                side_d.jf_we = 1'b1;
            end
            default: ;
        endcase
    end

    assign res_o   = res_d;
    assign dst_b_o = side_d.dst_b;
    assign cf_o    = side_d.cf;
    assign cf_we_o = side_d.cf_we;
    assign jf_o    = side_d.jf;
    assign jf_we_o = side_d.jf_we;

    always_comb begin
        AST_CF_WE_ONLY_ADD_ROT: assert (!cf_we_o || op_i == 3'd0 || op_i == 3'd3) else $error("cf strobe on op %0d", op_i); // R5
        AST_CF_ECHO: assert (cf_we_o || cf_o == cf_i) else $error("cf not echoed"); // R9
        AST_JF_ECHO: assert (jf_we_o || jf_o == jf_i) else $error("jf not echoed"); // R9
        AST_DST_B_ONLY_INVB: assert (!dst_b_o || op_i == 3'd5) else $error("dest B on op %0d", op_i); // R7
        AST_UNUSED_QUIET: assert (op_i < 3'd6 || (res_o == '0 && !cf_we_o && !jf_we_o && !dst_b_o)) else $error("unused op active"); // R8
    end
endmodule

// File: tb/nib_alu_bench.sv
module nib_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op;
    logic [3:0] a, b;
    logic       cf, jf;
    logic [3:0] res;
    logic       dst_b, cf_n, cf_we, jf_n, jf_we;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    nib_alu u_nib_alu (
        .op_i(op), .a_i(a), .b_i(b), .cf_i(cf), .jf_i(jf),
        .res_o(res), .dst_b_o(dst_b), .cf_o(cf_n), .cf_we_o(cf_we),
        .jf_o(jf_n), .jf_we_o(jf_we)
    );

    // {op, a, b, cf, jf, res, dst_b, cf, cf_we, jf, jf_we}
    localparam logic [21:0] VEC [10] = '{
        {3'd0, 4'h7, 4'h8, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {3'd0, 4'h3, 4'h4, 1'b0, 1'b1, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd0, 4'h5, 4'h3, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'd1, 4'hF, 4'hF, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'd2, 4'hA, 4'h5, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd3, 4'h1, 4'h0, 1'b1, 1'b1, 4'h8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 4'hE, 4'h0, 1'b0, 1'b0, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd4, 4'hF, 4'h3, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'd5, 4'hF, 4'h0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {3'd6, 4'hF, 4'hF, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1/R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // independent model: returns {res, dst_b, cf, cf_we, jf, jf_we}
    function automatic logic [8:0] model(input logic [2:0] o, input logic [3:0] x,
                                         input logic [3:0] y, input logic c, input logic j);
        logic [4:0] s;
        logic [3:0] r;
        logic d, cn, cw, jn, jw;
        r = 4'h0; d = 1'b0; cn = c; cw = 1'b0; jn = j; jw = 1'b0;   // R9 echo
        case (o)
            3'd0: begin s = x + y + c; r = s[3:0]; cn = s[4]; cw = 1'b1; jn = s[3]; jw = 1'b1; end
            3'd1: r = ~(x & y);
            3'd2: r = x ^ y;
            3'd3: begin r = {c, x[3:1]}; cn = x[0]; cw = 1'b1; end
            3'd4: begin r = ~x; jn = (x == 4'hF); jw = 1'b1; end
            3'd5: begin r = ~y; d = 1'b1; jn = (y == 4'hF); jw = 1'b1; end
            default: ;
        endcase
        return {r, d, cn, cw, jn, jw};
    endfunction

    task automatic compare(input logic [8:0] exp, input string tag);
        logic [8:0] got;
        got = {res, dst_b, cf_n, cf_we, jf_n, jf_we};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h cf=%b jf=%b got=%h expected=%h",
                     tag, op, a, b, cf, jf, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y,
                         input logic c, input logic j);
        @(posedge clk);
        op = o; a = x; b = y; cf = c; jf = j;
        #1;
    endtask

    initial begin
        op = 3'd0; a = 4'h0; b = 4'h0; cf = 1'b0; jf = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // quiescent state after reset: all-zero add gives zero sum, both strobes (R1, R2)
        #1 compare({4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, "R1/R2 idle");

        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][21:19], VEC[i][18:15], VEC[i][14:11], VEC[i][10], VEC[i][9]);
            compare(VEC[i][8:0], tag_of(VEC[i][21:19]));
        end

        // exhaustive sweep, flag echo R9 covered by the model
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    for (int cj = 0; cj < 4; cj++) begin
                        apply(3'(o), 4'(x), 4'(y), cj[1], cj[0]);
                        compare(model(3'(o), 4'(x), 4'(y), cj[1], cj[0]), tag_of(3'(o)));
                    end

        // corners: invert A of zero is not zero, jf cleared over a set input (R6)
        apply(3'd4, 4'h0, 4'h0, 1'b0, 1'b1);
        compare({4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, "R6 corner");
        // add overflow to sign bit with carry in (R2)
        apply(3'd0, 4'h7, 4'h0, 1'b1, 1'b0);
        compare({4'h8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, "R2 corner");
        // unused code 7 echoes flags (R8, R9)
        apply(3'd7, 4'h9, 4'h6, 1'b0, 1'b1);
        compare({4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R8/R9 corner");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule